// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with two escalation stages. A prescaler divides the clock into a slow tick. A 10-bit down-counter consumes those ticks. When the count runs out, the counter refills itself from a programmable start value and records a timeout. The first timeout only raises a status flag and, if enabled, a one-cycle event request. If the count runs out again before software has cleared that flag, the block records a second timeout. It then asks for a system reset, unless a reboot-inhibit bit holds the reset back.

Software reaches the block through a flat register port. There is a write strobe with address and data, and a read path that is combinational on the address. Software keeps the system alive by writing the restart key, which refills the counter, and by clearing the timeout flag. It can freeze the counter with a halt bit and read the live count at any time. With a tick of 0.6 s, PRESCALE_DIV is set to the number of clock cycles in 0.6 s.

Top module: `two_stage_wdt`

Register map (3-bit address, 16-bit data): 0 = restart/count, 1 = start value, 2 = first-stage status, 3 = second-stage status, 4 = control, 5 = event enable.

## Requirements
- R1: After reset: halt is 1, inhibit is 1, the start value and the count are 0x004, the event enable is 0, all status flags are clear, and evt_req and rst_req are low. Control therefore reads 0x0801.
- R2: A write to address 1 whose bits 9:0 are 4 or more stores all 16 bits, and a read returns them. A write whose bits 9:0 are 0 to 3 is ignored entirely.
- R3: Writing exactly 0x0001 to address 0 loads the count with the start value and restarts the prescaler, even while halted. Any other value written there is ignored. Reading address 0 returns the count in bits 9:0 and zeros above.
- R4: Control bit 11 is halt. While it is 1 the count holds. While it is 0 the count drops by one every PRESCALE_DIV clock cycles. Control bit 11 and bit 0 read back as written.
- R5: A tick that arrives with the count at zero is an expiry. The count reloads the start value, and status bit 3 at address 2 sets. An expiry therefore occurs (start+1)*PRESCALE_DIV cycles after a restart write.
- R6: Status bit 3 at address 2 clears when 1 is written to it. Writing 0 leaves it unchanged. An expiry in the same cycle as the clear wins. Once cleared, the next expiry counts as a first stage again.
- R7: An expiry with status bit 3 clear pulses evt_req high for exactly one cycle, but only if bit 13 at address 5 is 1. When that bit is 0, no pulse occurs.
- R8: An expiry with status bit 3 already set sets bit 1 at address 3. If control bit 0 (inhibit) is 0, it also drives rst_req high for RST_PULSE_CYC cycles and sets bit 2 at address 3.
- R9: While inhibit is 1, a second-stage expiry still sets bit 1 at address 3, but rst_req stays low and bit 2 stays clear.
- R10: Bits 1 and 2 at address 3 each clear when 1 is written to that bit. A 0 leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| evt_req | output | 1 | One-cycle first-stage event request |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench measures the exact cycle distance from a restart write to the first expiry, and from one expiry to the next. A counter that expires at one instead of zero, or a prescaler that is not restarted, is off by one period and shows up there. It checks that start values below four are dropped whole: a design that clamps them or stores only the upper bits reads back the wrong word. It also checks that clearing the first-stage flag turns the next expiry back into a first stage. It shows that inhibit holds back the reset while the second-stage flag is still recorded; a design that gates the flag instead loses that record. Writes of 0 to write-one-to-clear flags, and non-key writes to the restart address, are each checked to change nothing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 10;

  localparam logic [ADDR_W-1:0] A_RESTART = 3'd0;
  localparam logic [ADDR_W-1:0] A_START   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT1   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT2   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVTEN   = 3'd5;

  localparam int HALT_BIT   = 11;
  localparam int INH_BIT    = 0;
  localparam int TOUT_BIT   = 3;
  localparam int SECOND_BIT = 1;
  localparam int BOOT_BIT   = 2;
  localparam int EVTEN_BIT  = 13;

  localparam logic [DATA_W-1:0] RESTART_KEY = 16'h0001;
  localparam logic [CNT_W-1:0]  START_MIN   = 10'd4;
  localparam logic [DATA_W-1:0] START_RST   = 16'h0004;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = run_i && wrap && !restart_i;

  always_comb begin
    div_d = div_q;
    if (restart_i) begin
      div_d = '0;
    end else if (run_i) begin
      div_d = wrap ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] start_i,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = tick_i && !load_i && at_zero;
  assign count_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = start_i;
    end else if (tick_i) begin
      cnt_d = at_zero ? start_i : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= START_RST[CNT_W-1:0];
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(LEN);

  logic [PW-1:0] left_q, left_d;

  assign pulse_o = (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (fire_i) begin
      left_d = LOAD;
    end else if (pulse_o) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              restart_o,
  output logic              halt_o,
  output logic              inhibit_o,
  output logic [DATA_W-1:0] start_o,
  output logic              evt_fire_o,
  output logic              rst_fire_o,
  output logic              stat1_o,
  output logic              boot_o
);
  logic [DATA_W-1:0] start_q, start_d;
  logic halt_q, halt_d, inh_q, inh_d, evten_q, evten_d;
  logic stat1_q, stat1_d, second_q, second_d, boot_q, boot_d;
  logic wr_start, wr_ctrl, wr_evten, wr_stat1, wr_stat2;
  logic start_ok, first_stage, second_stage;

  assign wr_start = wr_en && (addr == A_START);
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_evten = wr_en && (addr == A_EVTEN);
  assign wr_stat1 = wr_en && (addr == A_STAT1);
  assign wr_stat2 = wr_en && (addr == A_STAT2);
  assign restart_o = wr_en && (addr == A_RESTART) && (wr_data == RESTART_KEY);

  assign start_ok     = (wr_data[CNT_W-1:0] >= START_MIN);
  assign first_stage  = expire_i && !stat1_q;
  assign second_stage = expire_i && stat1_q;
  assign evt_fire_o   = first_stage && evten_q;
  assign rst_fire_o   = second_stage && !inh_q;

  always_comb begin
    start_d  = start_q;
    halt_d   = halt_q;
    inh_d    = inh_q;
    evten_d  = evten_q;
    stat1_d  = stat1_q;
    second_d = second_q;
    boot_d   = boot_q;
    if (wr_start && start_ok) start_d = wr_data;
    if (wr_ctrl) begin
      halt_d = wr_data[HALT_BIT];
      inh_d  = wr_data[INH_BIT];
    end
    if (wr_evten) evten_d = wr_data[EVTEN_BIT];
    if (wr_stat1 && wr_data[TOUT_BIT]) stat1_d = 1'b0;
    if (expire_i) stat1_d = 1'b1;
    if (wr_stat2 && wr_data[SECOND_BIT]) second_d = 1'b0;
    if (wr_stat2 && wr_data[BOOT_BIT]) boot_d = 1'b0;
    if (second_stage) second_d = 1'b1;
    if (rst_fire_o) boot_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= START_RST;
      halt_q   <= 1'b1;
      inh_q    <= 1'b1;
      evten_q  <= 1'b0;
      stat1_q  <= 1'b0;
      second_q <= 1'b0;
      boot_q   <= 1'b0;
    end else begin
      start_q  <= start_d;
      halt_q   <= halt_d;
      inh_q    <= inh_d;
      evten_q  <= evten_d;
      stat1_q  <= stat1_d;
      second_q <= second_d;
      boot_q   <= boot_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr)
      A_RESTART: rd_data_o[CNT_W-1:0] = count_i;
      A_START:   rd_data_o = start_q;
      A_STAT1:   rd_data_o[TOUT_BIT] = stat1_q;
      A_STAT2: begin
        rd_data_o[SECOND_BIT] = second_q;
        rd_data_o[BOOT_BIT]   = boot_q;
      end
      A_CTRL: begin
        rd_data_o[HALT_BIT] = halt_q;
        rd_data_o[INH_BIT]  = inh_q;
      end
      A_EVTEN:   rd_data_o[EVTEN_BIT] = evten_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign halt_o    = halt_q;
  assign inhibit_o = inh_q;
  assign start_o   = start_q;
  assign stat1_o   = stat1_q;
  assign boot_o    = boot_q;
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV  = 75_000_000,
  parameter int unsigned RST_PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              evt_req,
  output logic              rst_req
);
  logic              restart, halt, inhibit, tick, expire;
  logic              evt_fire, rst_fire, stat1_flag, boot_flag;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] start_val;

  wdt_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .count_i(count), .expire_i(expire), .rd_data_o(rd_data),
    .restart_o(restart), .halt_o(halt), .inhibit_o(inhibit), .start_o(start_val),
    .evt_fire_o(evt_fire), .rst_fire_o(rst_fire),
    .stat1_o(stat1_flag), .boot_o(boot_flag)
  );

  wdt_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(!halt), .restart_i(restart), .tick_o(tick)
  );

  wdt_down_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start_val[CNT_W-1:0]), .load_i(restart),
    .tick_i(tick), .count_o(count), .expire_o(expire)
  );

  wdt_pulse #(.LEN(1)) u_evt_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(evt_fire), .pulse_o(evt_req)
  );

  wdt_pulse #(.LEN(RST_PULSE_CYC)) u_rst_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(rst_fire), .pulse_o(rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [15:0] wr_data,
  input logic        evt_req,
  input logic        rst_req,
  input logic        halt,
  input logic        inhibit,
  input logic [9:0]  count,
  input logic [15:0] start_val,
  input logic        stat1,
  input logic        boot
);
  a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt_req |=> !evt_req);

  a_r4_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(wr_en && addr == 3'd0 && wr_data == 16'h0001)) |=> $stable(count));

  a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !$past(inhibit));

  a_r8_boot_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> boot);

  a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat1) |-> $past(wr_en && addr == 3'd2 && wr_data[3]));

  a_r2_start_floor: assert property (@(posedge clk) disable iff (!rst_n)
    start_val[9:0] >= 10'd4);
endmodule

bind two_stage_wdt wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .evt_req(evt_req), .rst_req(rst_req), .halt(halt), .inhibit(inhibit),
  .count(count), .start_val(start_val), .stat1(stat1_flag), .boot(boot_flag)
);

// File: tb/tb_two_stage_wdt.sv
module tb_two_stage_wdt;
  localparam int DIV = 4;
  localparam int RLEN = 5;
  localparam int START = 6;
  localparam int PERIOD = (START + 1) * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        evt_req, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  two_stage_wdt #(.PRESCALE_DIV(DIV), .RST_PULSE_CYC(RLEN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .evt_req(evt_req), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, int'(v), int'(exp));
  endtask

  // sel 0: evt_req, 1: rst_req, 2: rd_data[bitpos] at address a
  task automatic wait_cond(input int sel, input logic [2:0] a, input int bitpos,
                           input int maxc, output int n, output bit saw_rst,
                           output bit saw_evt);
    bit hit;
    n = 0; saw_rst = 0; saw_evt = 0; hit = 0;
    addr = a;
    while (!hit && n < maxc) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      #1;
      if (rst_req) saw_rst = 1;
      if (evt_req) saw_evt = 1;
      case (sel)
        0: hit = evt_req;
        1: hit = rst_req;
        default: hit = rd_data[bitpos];
      endcase
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 count", 3'd0, 16'h0004);
    rd_chk("R1 start", 3'd1, 16'h0004);
    rd_chk("R1 stat1", 3'd2, 16'h0000);
    rd_chk("R1 stat2", 3'd3, 16'h0000);
    rd_chk("R1 ctrl", 3'd4, 16'h0801);
    rd_chk("R1 evten", 3'd5, 16'h0000);
    chk("R1 evt_req", int'(evt_req), 0);
    chk("R1 rst_req", int'(rst_req), 0);
  endtask

  task automatic t_start_reg;
    wr(3'd1, 16'hFC07);
    rd_chk("R2 full word", 3'd1, 16'hFC07);
    wr(3'd1, 16'h0403);
    rd_chk("R2 low 3 ignored", 3'd1, 16'hFC07);
    wr(3'd1, 16'h0000);
    rd_chk("R2 zero ignored", 3'd1, 16'hFC07);
    wr(3'd1, 16'h0004);
    rd_chk("R2 four accepted", 3'd1, 16'h0004);
  endtask

  task automatic t_halt_run;
    logic [15:0] c1, c2;
    wr(3'd1, 16'(START));
    wr(3'd0, 16'h0001);
    rd_chk("R3 restart while halted", 3'd0, 16'(START));
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd_chk("R4 halted holds", 3'd0, 16'(START));
    wr(3'd4, 16'h0001);
    rd_chk("R4 ctrl readback", 3'd4, 16'h0001);
    wr(3'd0, 16'h0001);
    repeat (8) @(posedge clk);
    @(negedge clk);
    rd_chk("R4 two ticks", 3'd0, 16'(START - 2));
    wr(3'd4, 16'h0801);
    rd(3'd0, c1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(3'd0, c2);
    chk("R4 halt stops", int'(c2), int'(c1));
    wr(3'd0, 16'h0002);
    rd_chk("R3 non-key ignored", 3'd0, c1);
    wr(3'd0, 16'h0001);
    rd_chk("R3 key reloads", 3'd0, 16'(START));
  endtask

  task automatic t_first_stage;
    int n; bit sr, se;
    wr(3'd5, 16'h2000);
    rd_chk("R7 evten readback", 3'd5, 16'h2000);
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0001);
    wait_cond(0, 3'd0, 0, 200, n, sr, se);
    chk("R5 R7 first expiry cycle", n, PERIOD);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R7 evt one cycle", int'(evt_req), 0);
    rd_chk("R5 stat1 set", 3'd2, 16'h0008);
    wr(3'd2, 16'h0000);
    rd_chk("R6 write 0 no effect", 3'd2, 16'h0008);
    wr(3'd2, 16'h0008);
    rd_chk("R6 write 1 clears", 3'd2, 16'h0000);
    wr(3'd4, 16'h0801);
  endtask

  task automatic t_second_inhibited;
    int n; bit sr, se;
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0001);
    wait_cond(0, 3'd0, 0, 200, n, sr, se);
    chk("R5 first expiry", n, PERIOD);
    wait_cond(2, 3'd3, 1, 200, n, sr, se);
    chk("R9 second flag cycle", n, PERIOD);
    chk("R9 no reset", int'(sr), 0);
    rd_chk("R9 boot clear", 3'd3, 16'h0002);
    wr(3'd4, 16'h0801);
    wr(3'd3, 16'h0006);
    rd_chk("R10 both cleared", 3'd3, 16'h0000);
    wr(3'd2, 16'h0008);
    rd_chk("R6 clear", 3'd2, 16'h0000);
  endtask

  task automatic t_second_reset;
    int n, w; bit sr, se;
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0001);
    wait_cond(2, 3'd2, 3, 200, n, sr, se);
    chk("R5 first expiry", n, PERIOD);
    chk("R7 no evt when disabled", int'(se), 0);
    wr(3'd2, 16'h0008);
    wait_cond(2, 3'd2, 3, 200, n, sr, se);
    chk("R6 rearmed no reset", int'(sr), 0);
    rd_chk("R6 rearmed no second", 3'd3, 16'h0000);
    wait_cond(1, 3'd3, 0, 200, n, sr, se);
    chk("R8 reset cycle", n, PERIOD);
    w = 1;
    forever begin
      @(posedge clk);
      @(negedge clk);
      #1;
      if (!rst_req) break;
      w++;
    end
    chk("R8 reset width", w, RLEN);
    rd_chk("R8 second and boot", 3'd3, 16'h0006);
    wr(3'd4, 16'h0801);
    wr(3'd3, 16'h0002);
    rd_chk("R10 per-bit clear", 3'd3, 16'h0004);
    wr(3'd3, 16'h0000);
    rd_chk("R10 write 0 no effect", 3'd3, 16'h0004);
    wr(3'd3, 16'h0004);
    rd_chk("R10 boot cleared", 3'd3, 16'h0000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_reg();
    t_halt_run();
    t_first_stage();
    t_second_inhibited();
    t_second_reset();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule